// File: doc/BRIEF.md
# Packet Framing Monitor for a Valid/Busy Link

This block sits beside a single-clock, point-to-point link and watches it without driving anything. The sender raises a valid strobe and presents a command word. The receiver may hold it off with a busy strobe. A beat moves across the link only on a clock edge where valid is high and busy is low. That is the link's back-pressure rule: while busy is high, the sender must hold the beat, and the monitor treats that cycle as if nothing happened. The monitor looks only at the command word. The payload travelling alongside it is never decoded.

Each accepted command falls into one of three kinds. It is an opener if it equals the opener code, a closer if it equals the closer code, and a body beat otherwise. Legal traffic is a back-to-back series of packets, and the series may be empty. Each packet is one opener, then any number of body beats, then one closer, and packets never overlap. The monitor tracks whether a packet is open. It reports the first framing violation through a sticky flag with a cause code, pulses once for every packet it sees closed, and keeps a saturating count of closed packets. A separate drain input lets the surrounding logic ask, at a quiet point such as the end of a test or a flush, whether a packet has been left dangling.

Top module: `pkt_frame_monitor`

## Requirements
- R1: A beat is taken only at a rising edge where `mon_valid`=1 and `mon_busy`=0. Stalled cycles (valid=1, busy=1) and idle cycles (valid=0) change neither the error outputs, the pulse nor the counter, whatever command they carry.
- R2: An opener beat (command equal to `OPEN_CODE` in all `CMD_W` bits) taken while no packet is open opens a packet and raises no error.
- R3: Any taken command that differs from both `OPEN_CODE` and `CLOSE_CODE` in at least one bit is a body beat. A body beat inside an open packet raises no error.
- R4: A closer beat (command equal to `CLOSE_CODE`) taken inside an open packet closes it. `pkt_done` is 1 in exactly the cycle after that edge, and `pkt_count` rises by one at the same edge.
- R5: An opener taken while a packet is open raises the error with cause 1 (nested opener).
- R6: A body or closer beat taken while no packet is open raises the error with cause 2 (orphan beat).
- R7: `drain_chk`=1 at an edge raises the error with cause 3 (left open) if a packet is open after that edge's beat. A closer taken in the same cycle as the drain request therefore raises no error.
- R8: Once raised, `err_flag` stays 1 and `err_cause` keeps its first value until reset. If a beat error and a drain error arise at the same edge, the beat error's cause is recorded. With `err_flag`=0, `err_cause` reads 0.
- R9: `pkt_count` saturates at 2^`CNT_W`-1. Further closed packets still pulse `pkt_done` but leave the count unchanged.
- R10: A synchronous active-high `rst` clears the error flag and cause, the pulse and the counter, and leaves no packet open.
- R11: After a nested opener the packet stays open. Framing checks and closing continue normally, so a following closer pulses `pkt_done` and counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous reset, active high |
| mon_valid | input | 1 | Sender's valid strobe, observed |
| mon_busy | input | 1 | Receiver's busy strobe, observed |
| mon_cmd | input | CMD_W (24) | Command word on the link |
| drain_chk | input | 1 | Request to check that no packet is open |
| err_flag | output | 1 | Sticky framing error |
| err_cause | output | 2 | 0 none, 1 nested opener, 2 orphan beat, 3 left open |
| pkt_done | output | 1 | One-cycle pulse per closed packet |
| pkt_count | output | CNT_W (16) | Saturating closed-packet count |

## Verification
Two functions can fall in the same cycle: framing a taken beat and judging a drain request. They are provoked together in two ways. A closer arrives with `drain_chk` high, and the expected result is no error plus a counted packet. An opener arrives with `drain_chk` high, both inside an open packet, and the expected result is cause 1, not cause 3. The random phase raises drain requests at arbitrary points in packets. The bench's reference model judges each one against the packet state that holds after that cycle's beat.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

  // Error cause codes, as seen on err_cause
  typedef enum logic [1:0] {
    CAUSE_NONE          = 2'd0,
    CAUSE_NESTED_OPEN   = 2'd1,
    CAUSE_ORPHAN        = 2'd2,
    CAUSE_LEFT_OPEN     = 2'd3
  } pfm_cause_e;

  // Kind of a command word
  typedef enum logic [1:0] {
    KIND_OPEN  = 2'd0,
    KIND_BODY  = 2'd1,
    KIND_CLOSE = 2'd2
  } pfm_kind_e;

  // One observed beat after decoding
  typedef struct packed {
    logic      take;
    pfm_kind_e kind;
  } pfm_beat_t;

  // Framing state between edges
  typedef enum logic {
    FR_IDLE = 1'b0,
    FR_OPEN = 1'b1
  } pfm_frame_e;

endpackage

// File: rtl/pfm_beat_decode.sv
module pfm_beat_decode
  import pfm_pkg::*;
#(
  parameter int               CMD_W      = 24,
  parameter logic [CMD_W-1:0] OPEN_CODE  = 24'h5A0001,
  parameter logic [CMD_W-1:0] CLOSE_CODE = 24'h5A00FF
) (
  input  logic             valid,
  input  logic             busy,
  input  logic [CMD_W-1:0] cmd,
  output pfm_beat_t        beat
);

  logic is_open;
  logic is_close;

  // Full-width comparison: a single differing bit makes a body beat
  assign is_open  = (cmd == OPEN_CODE);
  assign is_close = (cmd == CLOSE_CODE);

  always_comb begin
    beat.take = valid & ~busy;
    if (is_open)       beat.kind = KIND_OPEN;
    else if (is_close) beat.kind = KIND_CLOSE;
    else               beat.kind = KIND_BODY;
  end

endmodule

// File: rtl/pfm_frame_tracker.sv
module pfm_frame_tracker
  import pfm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pfm_beat_t  beat,
  input  logic       drain_chk,
  output logic       closing,
  output logic       err_flag,
  output pfm_cause_e err_cause
);

  pfm_frame_e state_q;
  pfm_frame_e state_d;
  pfm_cause_e beat_cause;
  logic       beat_bad;
  logic       drain_bad;

  // Next framing state and per-beat verdict
  always_comb begin
    state_d    = state_q;
    beat_cause = CAUSE_NONE;
    closing    = 1'b0;
    if (beat.take) begin
      unique case (beat.kind)
        KIND_OPEN: begin
          if (state_q == FR_OPEN) beat_cause = CAUSE_NESTED_OPEN;
          state_d = FR_OPEN;
        end
        KIND_CLOSE: begin
          if (state_q == FR_OPEN) begin
            closing = 1'b1;
            state_d = FR_IDLE;
          end else begin
            beat_cause = CAUSE_ORPHAN;
          end
        end
        default: begin
          if (state_q == FR_IDLE) beat_cause = CAUSE_ORPHAN;
        end
      endcase
    end
  end

  assign beat_bad  = (beat_cause != CAUSE_NONE);
  // Drain is judged on the state left after this cycle's beat
  assign drain_bad = drain_chk & (state_d == FR_OPEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= FR_IDLE;
      err_flag  <= 1'b0;
      err_cause <= CAUSE_NONE;
    end else begin
      state_q <= state_d;
      if (!err_flag) begin
        if (beat_bad) begin
          err_flag  <= 1'b1;
          err_cause <= beat_cause;
        end else if (drain_bad) begin
          err_flag  <= 1'b1;
          err_cause <= CAUSE_LEFT_OPEN;
        end
      end
    end
  end

endmodule

// File: rtl/pfm_pkt_tally.sv
module pfm_pkt_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             closing,
  output logic             pkt_done,
  output logic [CNT_W-1:0] pkt_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_done  <= 1'b0;
      pkt_count <= '0;
    end else begin
      pkt_done <= closing;
      if (closing && (pkt_count != CNT_MAX)) pkt_count <= pkt_count + 1'b1;
    end
  end

endmodule

// File: rtl/pkt_frame_monitor.sv
module pkt_frame_monitor
  import pfm_pkg::*;
#(
  parameter int               CMD_W      = 24,
  parameter int               CNT_W      = 16,
  parameter logic [CMD_W-1:0] OPEN_CODE  = 24'h5A0001,
  parameter logic [CMD_W-1:0] CLOSE_CODE = 24'h5A00FF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mon_valid,
  input  logic             mon_busy,
  input  logic [CMD_W-1:0] mon_cmd,
  input  logic             drain_chk,
  output logic             err_flag,
  output logic [1:0]       err_cause,
  output logic             pkt_done,
  output logic [CNT_W-1:0] pkt_count
);

  pfm_beat_t  beat;
  pfm_cause_e cause;
  logic       closing;

  pfm_beat_decode #(
    .CMD_W     (CMD_W),
    .OPEN_CODE (OPEN_CODE),
    .CLOSE_CODE(CLOSE_CODE)
  ) u_decode (
    .valid(mon_valid),
    .busy (mon_busy),
    .cmd  (mon_cmd),
    .beat (beat)
  );

  pfm_frame_tracker u_track (
    .clk      (clk),
    .rst      (rst),
    .beat     (beat),
    .drain_chk(drain_chk),
    .closing  (closing),
    .err_flag (err_flag),
    .err_cause(cause)
  );

  assign err_cause = cause;

  pfm_pkt_tally #(
    .CNT_W(CNT_W)
  ) u_tally (
    .clk      (clk),
    .rst      (rst),
    .closing  (closing),
    .pkt_done (pkt_done),
    .pkt_count(pkt_count)
  );

endmodule

// File: rtl/pfm_checker.sv
module pfm_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             mon_valid,
  input logic             mon_busy,
  input logic             drain_chk,
  input logic             err_flag,
  input logic [1:0]       err_cause,
  input logic             pkt_done,
  input logic [CNT_W-1:0] pkt_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // No beat and no drain request: nothing may move
  p_quiet_cycle_r1: assert property (@(posedge clk) disable iff (rst)
    (!(mon_valid && !mon_busy) && !drain_chk) |=> (err_flag == $past(err_flag)) && !pkt_done);

  // Two closes need an opener between them, so pulses never touch
  p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
    pkt_done |=> !pkt_done);

  // Count moves only together with the pulse
  p_count_with_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (pkt_count != $past(pkt_count)) |-> pkt_done);

  // Error is sticky with a frozen cause
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag && $stable(err_cause));

  // Cause is nonzero exactly when the flag is up
  p_cause_matches_flag_r8: assert property (@(posedge clk) disable iff (rst)
    err_flag == (err_cause != 2'd0));

  // Saturated count stays put
  p_count_saturates_r9: assert property (@(posedge clk) disable iff (rst)
    (pkt_count == CNT_MAX) |=> (pkt_count == CNT_MAX));

  // Reset clears outputs at the next edge
  p_reset_clears_r10: assert property (@(posedge clk)
    rst |=> !err_flag && !pkt_done && (pkt_count == '0));

endmodule

bind pkt_frame_monitor pfm_checker #(.CNT_W(CNT_W)) u_pfm_chk (
  .clk      (clk),
  .rst      (rst),
  .mon_valid(mon_valid),
  .mon_busy (mon_busy),
  .drain_chk(drain_chk),
  .err_flag (err_flag),
  .err_cause(err_cause),
  .pkt_done (pkt_done),
  .pkt_count(pkt_count)
);

// File: tb/test_pkt_frame_monitor.sv
`timescale 1ns/1ps
module test_pkt_frame_monitor;

  localparam int          CW    = 24;
  localparam int          NW    = 4;
  localparam logic [23:0] OPN   = 24'h5A0001;
  localparam logic [23:0] CLS   = 24'h5A00FF;
  localparam logic [23:0] BODY  = 24'h000000;
  localparam int          NMAX  = (1 << NW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mon_valid = 1'b0;
  logic          mon_busy = 1'b0;
  logic [CW-1:0] mon_cmd = '0;
  logic          drain_chk = 1'b0;
  logic          err_flag;
  logic [1:0]    err_cause;
  logic          pkt_done;
  logic [NW-1:0] pkt_count;

  int checks = 0;
  int errors = 0;

  // Reference model state
  bit m_open;
  bit m_err;
  int m_cause;
  bit m_done;
  int m_cnt;

  always #5 clk = ~clk;

  pkt_frame_monitor #(
    .CMD_W(CW), .CNT_W(NW), .OPEN_CODE(OPN), .CLOSE_CODE(CLS)
  ) i_pkt_frame_monitor (
    .clk(clk), .rst(rst), .mon_valid(mon_valid), .mon_busy(mon_busy),
    .mon_cmd(mon_cmd), .drain_chk(drain_chk), .err_flag(err_flag),
    .err_cause(err_cause), .pkt_done(pkt_done), .pkt_count(pkt_count)
  );

  function automatic int beat_verdict(bit open, logic [23:0] c);
    if (c == OPN) return open ? 1 : 0;
    if (c == CLS) return open ? 0 : 2;
    return open ? 0 : 2;
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (err_flag !== m_err || err_cause !== 2'(m_cause) ||
        pkt_done !== m_done || pkt_count !== NW'(m_cnt)) begin
      errors++;
      $display("FAIL %s: got err=%0b cause=%0d done=%0b cnt=%0d, expected err=%0b cause=%0d done=%0b cnt=%0d",
               tag, err_flag, err_cause, pkt_done, pkt_count,
               m_err, m_cause, m_done, m_cnt);
    end
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1; mon_valid = 1'b0; drain_chk = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    m_open = 0; m_err = 0; m_cause = 0; m_done = 0; m_cnt = 0;
    compare(tag);
    rst = 1'b0;
  endtask

  task automatic step(input bit v, input bit b, input logic [23:0] c,
                      input bit d, input string tag);
    int  bc;
    bit  nopen;
    mon_valid = v; mon_busy = b; mon_cmd = c; drain_chk = d;
    @(posedge clk);
    bc = 0; nopen = m_open; m_done = 0;
    if (v && !b) begin
      bc = beat_verdict(m_open, c);
      if (c == OPN) nopen = 1;
      else if (c == CLS && m_open) begin nopen = 0; m_done = 1; end
    end
    if (!m_err) begin
      if (bc != 0) begin m_err = 1; m_cause = bc; end
      else if (d && nopen) begin m_err = 1; m_cause = 3; end
    end
    if (m_done && m_cnt < NMAX) m_cnt++;
    m_open = nopen;
    #1;
    compare(tag);
    mon_valid = 1'b0; drain_chk = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset("R10 reset state");

    // Stalls and idles with a closer on the bus are ignored
    step(1, 0, OPN, 0, "R2 opener");
    step(1, 1, CLS, 0, "R1 stalled closer");
    step(0, 0, CLS, 0, "R1 idle closer");
    step(0, 1, OPN, 0, "R1 idle opener");
    step(1, 0, BODY, 0, "R3 body");
    step(1, 0, CLS ^ 24'h800000, 0, "R3 near-closer is body");
    step(1, 0, OPN ^ 24'h000001, 0, "R3 near-opener is body");
    step(1, 0, CLS, 0, "R4 close pulse");
    step(0, 0, BODY, 0, "R4 pulse drops");
    step(1, 0, OPN, 0, "R2 empty packet open");
    step(1, 0, CLS, 0, "R4 empty packet close");

    // Closer and drain in one cycle
    step(1, 0, OPN, 0, "R2 open");
    step(1, 0, CLS, 1, "R7 close with drain");
    step(0, 0, BODY, 1, "R7 drain idle");
    step(1, 0, OPN, 0, "R2 open");
    step(1, 1, CLS, 1, "R7 drain while stalled open");
    step(1, 0, OPN, 0, "R8 sticky after drain");
    step(1, 0, CLS, 0, "R8 cause held");
    do_reset("R10 clears error");

    step(1, 0, CLS, 0, "R6 orphan closer");
    do_reset("R10 clears");
    step(1, 0, 24'h123456, 0, "R6 orphan body");
    do_reset("R10 clears");

    step(1, 0, OPN, 0, "R2 open");
    step(1, 0, OPN, 0, "R5 nested opener");
    step(1, 0, BODY, 0, "R11 still open body");
    step(1, 0, CLS, 0, "R11 close counts");
    do_reset("R10 clears");

    step(1, 0, OPN, 0, "R2 open");
    step(1, 0, OPN, 1, "R8 beat cause beats drain");
    do_reset("R10 clears");

    // Saturation
    for (int i = 0; i < NMAX + 2; i++) begin
      step(1, 0, OPN, 0, "R9 open");
      step(1, 0, CLS, 0, "R9 close near saturation");
    end
    do_reset("R10 clears count");

    // Random traffic biased toward legal framing
    for (int blk = 0; blk < 60; blk++) begin
      for (int i = 0; i < 50; i++) begin
        int          r;
        logic [23:0] c;
        r = $urandom_range(0, 99);
        if (m_open) c = (r < 30) ? CLS : (r < 35) ? OPN : 24'($urandom);
        else        c = (r < 92) ? OPN : (r < 96) ? CLS : 24'($urandom);
        step($urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0, c,
             $urandom_range(0, 24) == 0, "R1 R7 random traffic");
      end
      do_reset("R10 random block reset");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule